// File: doc/BRIEF.md
# Address-space-tagged translation cache with access permissions

This block is a small, fully associative cache of address translations. Each slot holds a virtual page number, the address-space tag of the process that owns it, a physical frame number, a two-bit access permission and a pinned flag. A lookup presents a page number, the current address-space tag and an access kind: read, write or execute. Every slot is compared at once. One cycle later the block reports exactly one of three results. A hit returns the frame number. A miss means no slot holds this page for this address space. A fault means a matching slot exists but its permission forbids the access.

After a miss, the surrounding logic walks the page table and writes the result through the fill port. A fill whose page and tag already sit in a slot replaces that slot. Any other fill takes a victim, which is chosen round-robin among the slots that are not pinned. If every slot is pinned, the fill is discarded and a one-cycle flag reports it. Two flush controls exist: one clears all unpinned slots, and the other clears only the unpinned slots that carry a given address-space tag. Pinned slots survive both flushes.

Top module: `tlb_asid`

## Requirements
- R1: After reset, no slot is valid, `rs_valid` and `fl_drop` are low, and the victim pointer stands at slot 0.
- R2: A lookup presented in cycle N gives its result in cycle N+1. `rs_valid` is high, and exactly one of `rs_hit`, `rs_miss`, `rs_fault` is high. A slot matches only if its page number and its address-space tag both equal the request.
- R3: After a fill, a later lookup of the same page and tag under a permitted access hits and returns the filled frame number.
- R4: The permission code is 0 for read-only, 1 for read-write, 2 for execute-only and 3 for no access. The access code is 0 for read, 1 for write and 2 for execute. Read is allowed by codes 0 and 1, write only by code 1, and execute only by code 2. A match with a forbidden access raises `rs_fault` with `rs_pfn` equal to 0.
- R5: A fill whose page number and tag match a valid slot overwrites that slot (frame, permission, pinned flag). It never creates a second match.
- R6: A fill that matches no slot goes to the first unpinned slot found by scanning upward from the victim pointer and wrapping around. The pointer then moves to the slot after the one written. An overwrite leaves the pointer where it is.
- R7: A pinned slot is never chosen as a victim and is never cleared by either flush.
- R8: If every slot is valid and pinned and a fill matches none of them, nothing is written and `fl_drop` is high for the one cycle after the fill.
- R9: `flush_all` invalidates every unpinned slot.
- R10: `flush_asid_en` invalidates only the unpinned slots whose tag equals `flush_asid`.
- R11: A lookup sees the contents from before any fill or flush in the same cycle. A fill in the same cycle as a flush is still installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| rs_valid | output | 1 | Result valid, one cycle after request |
| rs_hit | output | 1 | Translation found and permitted |
| rs_miss | output | 1 | No matching slot |
| rs_fault | output | 1 | Matching slot forbids the access |
| rs_pfn | output | PFN_W | Frame number on hit, else 0 |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | VPN_W | Fill page number |
| fl_asid | input | ASID_W | Fill address-space tag |
| fl_pfn | input | PFN_W | Fill frame number |
| fl_perm | input | 2 | Fill permission code |
| fl_wired | input | 1 | Pin the filled slot |
| fl_drop | output | 1 | Previous-cycle fill was discarded (all pinned) |
| flush_all | input | 1 | Invalidate all unpinned slots |
| flush_asid_en | input | 1 | Invalidate unpinned slots of one tag |
| flush_asid | input | ASID_W | Tag for the selective flush |

## Verification
The bench probes the full read/write/execute permission matrix. A design that decoded permissions wrongly would return a frame where it should fault, or fault on a legal access. It checks that the tag takes part in matching, which a design ignoring the tag would fail by hitting across address spaces. It fills the cache until it wraps with one slot pinned. The pinned slot must survive, and the next eviction must land on the oldest unpinned slot. A pointer that failed to skip pinned slots, or that stepped on overwrite, would evict the wrong page. It also fills every slot pinned to force a dropped fill, and it tests same-cycle fill with lookup and fill with flush. A design with its ordering reversed would hit too early or lose the new entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      PERM_RO = 2'd0,
      PERM_RW = 2'd1,
      PERM_XO = 2'd2,
      PERM_NA = 2'd3
   } perm_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_e;

   // R4: permission matrix
   function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
      logic ok;
      unique case (acc)
         ACC_RD:  ok = (perm == PERM_RO) || (perm == PERM_RW);
         ACC_WR:  ok = (perm == PERM_RW);
         ACC_EX:  ok = (perm == PERM_XO);
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int PFN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [ASID_W-1:0] fl_asid,
   input  logic              wr_en,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic [1:0]        wr_perm,
   input  logic              wr_wired,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid,
   output logic              lk_match,
   output logic              fl_match,
   output logic              pinned,
   output logic [PFN_W-1:0]  pfn_o,
   output logic [1:0]        perm_o
);

   logic              vld_q;
   logic              wired_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              kill;

   assign lk_match = vld_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
   assign fl_match = vld_q && (vpn_q == fl_vpn) && (asid_q == fl_asid);
   assign pinned   = vld_q && wired_q;
   assign kill     = vld_q && !wired_q &&
                     (flush_all || (flush_asid_en && (asid_q == flush_asid)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         wired_q <= 1'b0;
         vpn_q   <= '0;
         asid_q  <= '0;
         pfn_o   <= '0;
         perm_o  <= 2'd0;
      end else if (wr_en) begin
         vld_q   <= 1'b1;
         wired_q <= wr_wired;
         vpn_q   <= fl_vpn;
         asid_q  <= fl_asid;
         pfn_o   <= wr_pfn;
         perm_o  <= wr_perm;
      end else if (kill) begin
         vld_q   <= 1'b0;
         wired_q <= 1'b0;
      end
   end

   // R7
   wired_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pinned && !wr_en) |=> pinned);

   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !wired_q && flush_all && !wr_en) |=> !lk_match && !fl_match && !pinned);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  cand,
   input  logic          adv,
   output logic [IW-1:0] victim,
   output logic          found
);

   logic [IW-1:0] rr_q;
   logic [N-1:0]  upper;
   logic [N-1:0]  pick;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         upper[i] = cand[i] && (IW'(i) >= rr_q);
      end
      pick   = (|upper) ? upper : cand;
      found  = |cand;
      victim = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pick[i]) victim = IW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (adv) begin
         rr_q <= (victim == IW'(N - 1)) ? '0 : victim + IW'(1);
      end
   end

   // R6
   victim_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> found && cand[victim]);

   // R6
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rr_q <= IW'(N - 1));

endmodule

// File: rtl/tlb_sel.sv
module tlb_sel #(
   parameter int N     = 64,
   parameter int PFN_W = 16
) (
   input  logic [N-1:0]            match,
   input  logic [N-1:0][PFN_W-1:0] pfn_a,
   input  logic [N-1:0][1:0]       perm_a,
   output logic                    any,
   output logic [PFN_W-1:0]        pfn,
   output logic [1:0]              perm
);

   always_comb begin
      any  = |match;
      pfn  = '0;
      perm = 2'd0;
      for (int i = 0; i < N; i++) begin
         pfn  = pfn  | (pfn_a[i]  & {PFN_W{match[i]}});
         perm = perm | (perm_a[i] & {2{match[i]}});
      end
   end

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [1:0]        lk_acc,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic              rs_miss,
   output logic              rs_fault,
   output logic [PFN_W-1:0]  rs_pfn,
   input  logic              fl_valid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [ASID_W-1:0] fl_asid,
   input  logic [PFN_W-1:0]  fl_pfn,
   input  logic [1:0]        fl_perm,
   input  logic              fl_wired,
   output logic              fl_drop,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid
);
   import tlb_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 64 || ENTRIES > 1024) begin : g_bad_entries
      $error("tlb_asid: ENTRIES must lie in 64..1024");
   end
   if (VPN_W < 1 || ASID_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("tlb_asid: widths must be positive");
   end

   logic [ENTRIES-1:0]            lk_match;
   logic [ENTRIES-1:0]            fl_match;
   logic [ENTRIES-1:0]            pinned;
   logic [ENTRIES-1:0]            wr_en;
   logic [ENTRIES-1:0][PFN_W-1:0] pfn_a;
   logic [ENTRIES-1:0][1:0]       perm_a;
   logic [IDX_W-1:0]              victim;
   logic                          found;
   logic                          fl_hit;
   logic                          alloc;
   logic                          hit_any;
   logic [PFN_W-1:0]              hit_pfn;
   logic [1:0]                    hit_perm;
   logic                          ok;

   assign fl_hit = |fl_match;
   assign alloc  = fl_valid && !fl_hit && found;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign wr_en[g] = fl_valid && (fl_hit ? fl_match[g] : (found && (victim == IDX_W'(g))));

      tlb_entry #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_ent (
         .clk           (clk),
         .rst_n         (rst_n),
         .lk_vpn        (lk_vpn),
         .lk_asid       (lk_asid),
         .fl_vpn        (fl_vpn),
         .fl_asid       (fl_asid),
         .wr_en         (wr_en[g]),
         .wr_pfn        (fl_pfn),
         .wr_perm       (fl_perm),
         .wr_wired      (fl_wired),
         .flush_all     (flush_all),
         .flush_asid_en (flush_asid_en),
         .flush_asid    (flush_asid),
         .lk_match      (lk_match[g]),
         .fl_match      (fl_match[g]),
         .pinned        (pinned[g]),
         .pfn_o         (pfn_a[g]),
         .perm_o        (perm_a[g])
      );
   end

   tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_vic (
      .clk    (clk),
      .rst_n  (rst_n),
      .cand   (~pinned),
      .adv    (alloc),
      .victim (victim),
      .found  (found)
   );

   tlb_sel #(.N(ENTRIES), .PFN_W(PFN_W)) u_sel (
      .match  (lk_match),
      .pfn_a  (pfn_a),
      .perm_a (perm_a),
      .any    (hit_any),
      .pfn    (hit_pfn),
      .perm   (hit_perm)
   );

   assign ok = perm_allows(hit_perm, lk_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_pfn   <= '0;
         fl_drop  <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid && hit_any && ok;
         rs_fault <= lk_valid && hit_any && !ok;
         rs_miss  <= lk_valid && !hit_any;
         rs_pfn   <= (lk_valid && hit_any && ok) ? hit_pfn : '0;
         fl_drop  <= fl_valid && !fl_hit && !found;
      end
   end

   // R5
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match) && $onehot0(fl_match));

   // R2
   rs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);

   // R2
   one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);

   // R4
   fault_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> rs_pfn == '0);

   // R8
   drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_drop |-> $past(fl_valid));

   // R8
   drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && !found && !fl_hit) |-> wr_en == '0);

endmodule

// File: tb/tb_tlb_asid.sv
`timescale 1ns/1ps
module tb_tlb_asid;

   localparam int N      = 64;
   localparam int VPN_W  = 20;
   localparam int ASID_W = 8;
   localparam int PFN_W  = 16;
   localparam logic [1:0] RMISS = 2'd0, RHIT = 2'd1, RFLT = 2'd2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic [1:0]        lk_acc = '0;
   logic              rs_valid, rs_hit, rs_miss, rs_fault;
   logic [PFN_W-1:0]  rs_pfn;
   logic              fl_valid = 1'b0;
   logic [VPN_W-1:0]  fl_vpn = '0;
   logic [ASID_W-1:0] fl_asid = '0;
   logic [PFN_W-1:0]  fl_pfn = '0;
   logic [1:0]        fl_perm = '0;
   logic              fl_wired = 1'b0;
   logic              fl_drop;
   logic              flush_all = 1'b0;
   logic              flush_asid_en = 1'b0;
   logic [ASID_W-1:0] flush_asid = '0;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   tlb_asid #(.ENTRIES(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
      .rs_pfn(rs_pfn),
      .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_pfn(fl_pfn),
      .fl_perm(fl_perm), .fl_wired(fl_wired), .fl_drop(fl_drop),
      .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
   );

   typedef struct packed {
      logic              lookup;
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PFN_W-1:0]  pfn;
      logic [1:0]        pa;
      logic              wired;
      logic [1:0]        exp;
      logic [PFN_W-1:0]  epfn;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 20'h10, 8'd1, 16'h100, 2'd1, 1'b0, 2'd0, 16'h0},   // R3 fill RW
      '{1'b0, 20'h11, 8'd1, 16'h101, 2'd0, 1'b0, 2'd0, 16'h0},   // R3 fill RO
      '{1'b0, 20'h12, 8'd2, 16'h102, 2'd2, 1'b0, 2'd0, 16'h0},   // R3 fill XO
      '{1'b1, 20'h10, 8'd1, 16'h0,   2'd0, 1'b0, 2'd1, 16'h100}, // R4 RW read
      '{1'b1, 20'h10, 8'd1, 16'h0,   2'd1, 1'b0, 2'd1, 16'h100}, // R4 RW write
      '{1'b1, 20'h10, 8'd1, 16'h0,   2'd2, 1'b0, 2'd2, 16'h0},   // R4 RW exec
      '{1'b1, 20'h11, 8'd1, 16'h0,   2'd1, 1'b0, 2'd2, 16'h0},   // R4 RO write
      '{1'b1, 20'h11, 8'd1, 16'h0,   2'd0, 1'b0, 2'd1, 16'h101}, // R4 RO read
      '{1'b1, 20'h12, 8'd2, 16'h0,   2'd2, 1'b0, 2'd1, 16'h102}, // R4 XO exec
      '{1'b1, 20'h12, 8'd2, 16'h0,   2'd0, 1'b0, 2'd2, 16'h0},   // R4 XO read
      '{1'b1, 20'h12, 8'd1, 16'h0,   2'd2, 1'b0, 2'd0, 16'h0},   // R2 tag differs
      '{1'b1, 20'h13, 8'd1, 16'h0,   2'd0, 1'b0, 2'd0, 16'h0},   // R2 page absent
      '{1'b0, 20'h10, 8'd1, 16'h1AA, 2'd1, 1'b0, 2'd0, 16'h0},   // R5 overwrite
      '{1'b1, 20'h10, 8'd1, 16'h0,   2'd0, 1'b0, 2'd1, 16'h1AA}  // R5 new frame
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] res_code();
      if (!rs_valid) return 2'd3;
      if (rs_hit && !rs_miss && !rs_fault) return RHIT;
      if (!rs_hit && rs_miss && !rs_fault) return RMISS;
      if (!rs_hit && !rs_miss && rs_fault) return RFLT;
      return 2'd3;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                          input logic [PFN_W-1:0] p, input logic [1:0] pm,
                          input logic w, output logic drop);
      fl_valid = 1'b1; fl_vpn = v; fl_asid = a; fl_pfn = p; fl_perm = pm; fl_wired = w;
      @(negedge clk);
      drop = fl_drop;
      fl_valid = 1'b0;
   endtask

   task automatic do_look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                          input logic [1:0] acc, output logic [1:0] code,
                          output logic [PFN_W-1:0] p);
      lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_acc = acc;
      @(negedge clk);
      code = res_code();
      p = rs_pfn;
      lk_valid = 1'b0;
   endtask

   task automatic expect_look(input string req, input logic [VPN_W-1:0] v,
                              input logic [ASID_W-1:0] a, input logic [1:0] acc,
                              input logic [1:0] ecode, input logic [PFN_W-1:0] epfn);
      logic [1:0] c;
      logic [PFN_W-1:0] p;
      do_look(v, a, acc, c, p);
      check(req, {14'd0, c, p}, {14'd0, ecode, epfn});
   endtask

   task automatic do_flush(input logic all, input logic [ASID_W-1:0] a);
      flush_all = all; flush_asid_en = !all; flush_asid = a;
      @(negedge clk);
      flush_all = 1'b0; flush_asid_en = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic d;
      logic [1:0] c;
      logic [PFN_W-1:0] p;

      do_reset();
      // R1: reset state
      check("R1 rs_valid", rs_valid, 0);
      check("R1 fl_drop", fl_drop, 0);
      expect_look("R1 empty", 20'h10, 8'd1, 2'd0, RMISS, 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].lookup) begin
            do_look(VECS[i].vpn, VECS[i].asid, VECS[i].pa, c, p);
            check($sformatf("R2/R3/R4/R5 vec %0d", i), {14'd0, c, p},
                  {14'd0, VECS[i].exp, VECS[i].epfn});
         end else begin
            do_fill(VECS[i].vpn, VECS[i].asid, VECS[i].pfn, VECS[i].pa, VECS[i].wired, d);
            check($sformatf("R3 vec %0d drop", i), d, 0);
         end
      end

      // R10: selective flush of tag 1 only
      do_flush(1'b0, 8'd1);
      expect_look("R10 tag1 gone", 20'h10, 8'd1, 2'd0, RMISS, 0);
      expect_look("R10 tag1 gone b", 20'h11, 8'd1, 2'd0, RMISS, 0);
      expect_look("R10 tag2 kept", 20'h12, 8'd2, 2'd2, RHIT, 16'h102);
      // R9: flush all
      do_flush(1'b1, 8'd0);
      expect_look("R9 all gone", 20'h12, 8'd2, 2'd2, RMISS, 0);

      // R6 R7: round robin skips pinned slot 0
      do_reset();
      do_fill(20'h200, 8'd5, 16'h200, 2'd1, 1'b1, d);
      for (int i = 0; i < N - 1; i++) begin
         do_fill(20'h300 + VPN_W'(i), 8'd6, 16'h300 + PFN_W'(i), 2'd1, 1'b0, d);
      end
      expect_look("R6 full before wrap", 20'h300, 8'd6, 2'd0, RHIT, 16'h300);
      do_fill(20'h3FF, 8'd6, 16'h3FF, 2'd1, 1'b0, d);
      check("R6 no drop", d, 0);
      expect_look("R6 oldest evicted", 20'h300, 8'd6, 2'd0, RMISS, 0);
      expect_look("R6 next kept", 20'h301, 8'd6, 2'd0, RHIT, 16'h301);
      expect_look("R6 new present", 20'h3FF, 8'd6, 2'd1, RHIT, 16'h3FF);
      expect_look("R7 pinned survives", 20'h200, 8'd5, 2'd0, RHIT, 16'h200);
      do_flush(1'b1, 8'd0);
      expect_look("R9 unpinned cleared", 20'h301, 8'd6, 2'd0, RMISS, 0);
      expect_look("R7 pinned after flush_all", 20'h200, 8'd5, 2'd0, RHIT, 16'h200);
      do_flush(1'b0, 8'd5);
      expect_look("R7 pinned after tag flush", 20'h200, 8'd5, 2'd1, RHIT, 16'h200);

      // R8: all slots pinned
      do_reset();
      for (int i = 0; i < N; i++) begin
         do_fill(20'h400 + VPN_W'(i), 8'd7, 16'h400 + PFN_W'(i), 2'd0, 1'b1, d);
         if (d) check("R8 early drop", d, 0);
      end
      do_fill(20'h500, 8'd7, 16'h500, 2'd0, 1'b0, d);
      check("R8 drop flag", d, 1);
      @(negedge clk);
      check("R8 drop one cycle", fl_drop, 0);
      expect_look("R8 not installed", 20'h500, 8'd7, 2'd0, RMISS, 0);
      do_fill(20'h400, 8'd7, 16'h4AA, 2'd1, 1'b1, d);
      check("R5 overwrite while full", d, 0);
      expect_look("R5 overwritten frame", 20'h400, 8'd7, 2'd1, RHIT, 16'h4AA);

      // R11: same-cycle ordering
      do_reset();
      lk_valid = 1'b1; lk_vpn = 20'h600; lk_asid = 8'd3; lk_acc = 2'd0;
      fl_valid = 1'b1; fl_vpn = 20'h600; fl_asid = 8'd3; fl_pfn = 16'h600;
      fl_perm = 2'd0; fl_wired = 1'b0;
      @(negedge clk);
      lk_valid = 1'b0; fl_valid = 1'b0;
      check("R11 lookup sees old", {30'd0, res_code()}, {30'd0, RMISS});
      expect_look("R11 later hit", 20'h600, 8'd3, 2'd0, RHIT, 16'h600);
      fl_valid = 1'b1; fl_vpn = 20'h601; fl_pfn = 16'h601; flush_all = 1'b1;
      @(negedge clk);
      fl_valid = 1'b0; flush_all = 1'b0;
      expect_look("R11 flushed old", 20'h600, 8'd3, 2'd0, RMISS, 0);
      expect_look("R11 fill with flush kept", 20'h601, 8'd3, 2'd0, RHIT, 16'h601);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule